// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Mode

This block is a counter with a companion reload/capture register of the same width. Software programs it through a small word-wide write port. The counter advances on one of three sources: a machine-cycle tick, a faster state-time tick, or falling edges seen on an external count pin. A second external pin acts as a trigger or as a direction control, depending on the mode.

The block has three operating modes. In capture mode, a falling trigger edge snapshots the counter into the companion register. In auto-reload mode, the companion register is copied back into the counter when it wraps, and the counter may optionally count up or down under control of the trigger pin. In baud mode, the counter runs from the state-time tick, reloads on every wrap, and emits single-cycle overflow pulses that a serial transmitter and receiver use as bit clocks.

Two sticky flags combine into one interrupt request: an overflow flag and an external-event flag. The external-event flag is a plain event marker in most modes. In up/down mode it becomes an extra toggling count bit that does not interrupt.

Top module: `reload_timer16`

## Requirements
- R1: After reset, the control byte, the counter, the companion register and the down-count enable all read zero, and the interrupt and both baud pulses are low.
- R2: While the run bit (control bit 2) is 0, the counter and flags hold, whatever ticks or pin edges arrive.
- R3: In capture mode (run=1, both baud selects 0, capture select bit 0 = 1, counter select bit 1 = 0), the counter advances once per machine-cycle tick and ignores state-time ticks. It wraps from all-ones to zero and sets the overflow flag (bit 7), which drives the interrupt.
- R4: In auto-reload mode (capture select 0, down-count enable 0), a tick at all-ones loads the companion register and sets the overflow flag. Flags stay set until software writes the control byte.
- R5: In auto-reload mode with external enable (bit 3) set, a trigger-pin high sample followed by a low sample on consecutive machine-cycle ticks loads the companion register into the counter, taking priority over the same tick's increment, and sets the external flag (bit 6). With external enable at 0, the edge has no effect.
- R6: In capture mode with external enable set, a falling trigger edge copies the counter value of that cycle into the companion register and sets the external flag, while the counter still advances.
- R7: With counter select (bit 1) set, the counter advances once for each pin sample pair high-then-low taken at machine-cycle ticks. A held low level and pin changes between ticks do not advance it.
- R8: With down-count enable set in auto-reload mode and the trigger pin at 0, the counter decrements. A tick when the counter equals the companion register loads all-ones and sets the overflow flag. With the trigger pin at 1, it counts up and reloads at all-ones.
- R9: In up/down mode, every wrap in either direction toggles the external flag, and the external flag alone does not raise the interrupt. Trigger edges cause no reload there.
- R10: Setting either baud select (receive bit 5, transmit bit 4) gives baud mode. In baud mode the counter advances on state-time ticks only, the capture select is ignored, a wrap reloads from the companion register, and the overflow flag is never set. Each wrap produces a one-cycle pulse on the output of every selected direction, in the cycle after the wrap, when the counter shows the reloaded value.
- R11: In baud mode, trigger-pin edges have no effect even with external enable set.
- R12: A software write to the counter or control byte wins over a same-cycle hardware update of that register. Write selects: 0 = control byte, 1 = down-count enable (data bit 0), 2 = counter, 3 = companion register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| st_tick | input | 1 | State-time strobe, one clock wide |
| cnt_pin | input | 1 | External event input for counter function |
| trg_pin | input | 1 | External trigger / count direction input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | CNT_W | Write data |
| ctrl_o | output | 8 | Control byte with flags |
| dcen_o | output | 1 | Down-count enable |
| count_o | output | CNT_W | Counter value |
| reload_o | output | CNT_W | Companion reload/capture register |
| irq_o | output | 1 | Interrupt request |
| tx_baud_o | output | 1 | Transmit baud overflow pulse |
| rx_baud_o | output | 1 | Receive baud overflow pulse |

## Verification
The bench builds the block with CNT_W = 8. At that width, a full wrap takes at most 256 ticks, so every start value can be carried through to the overflow point. The bench sweeps capture-mode counting over start values spread across the whole range, and auto-reload over reload values at both ends of the range. Down-count underflow, the external-flag toggle, the baud pulse timing and the write-priority cases each fall within a few ticks, with expected counts worked out arithmetically.

// File: rtl/rt16_pkg.sv
package rt16_pkg;

   typedef struct packed {
      logic of_flag;
      logic ex_flag;
      logic rx_sel;
      logic tx_sel;
      logic ext_en;
      logic run;
      logic ext_cnt;
      logic cap_mode;
   } rt16_ctrl_t;

   typedef enum logic [1:0] {
      RT_OFF     = 2'd0,
      RT_RELOAD  = 2'd1,
      RT_CAPTURE = 2'd2,
      RT_BAUD    = 2'd3
   } rt16_mode_e;

   localparam logic [1:0] SEL_CTRL   = 2'd0;
   localparam logic [1:0] SEL_OPT    = 2'd1;
   localparam logic [1:0] SEL_COUNT  = 2'd2;
   localparam logic [1:0] SEL_RELOAD = 2'd3;

endpackage

// File: rtl/rt16_fall.sv
module rt16_fall #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_en,
   input  logic [N-1:0] pin,
   output logic [N-1:0] fall
);

   generate
      for (genvar g = 0; g < N; g++) begin : g_pin
         logic smp_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      smp_q <= 1'b0;
            else if (smp_en) smp_q <= pin[g];
         end
         // edge seen when previous sample high and this sample low
         assign fall[g] = smp_en & smp_q & ~pin[g];
      end
   endgenerate

endmodule

// File: rtl/rt16_ctl.sv
module rt16_ctl
   import rt16_pkg::*;
(
   input  rt16_ctrl_t ctrl,
   input  logic       dcen,
   input  logic       mc_tick,
   input  logic       st_tick,
   input  logic       cnt_fall,
   input  logic       trg_fall,
   input  logic       trg_pin,
   output rt16_mode_e mode,
   output logic       baud,
   output logic       updown,
   output logic       inc,
   output logic       count_up,
   output logic       wrap_zero,
   output logic       ext_reload,
   output logic       ext_capture
);

   logic tick_src;
   logic ext_ev;

   always_comb begin
      if (!ctrl.run)                        mode = RT_OFF;
      else if (ctrl.rx_sel || ctrl.tx_sel)  mode = RT_BAUD;
      else if (ctrl.cap_mode)               mode = RT_CAPTURE;
      else                                  mode = RT_RELOAD;
   end

   assign baud      = ctrl.rx_sel | ctrl.tx_sel;
   assign updown    = dcen && (mode == RT_RELOAD);
   assign tick_src  = (mode == RT_BAUD) ? st_tick : mc_tick;
   assign inc       = (mode != RT_OFF) && (ctrl.ext_cnt ? cnt_fall : tick_src);
   assign count_up  = !updown || trg_pin;
   assign wrap_zero = (mode == RT_CAPTURE);

   assign ext_ev      = ctrl.ext_en && trg_fall && !updown &&
                        ((mode == RT_RELOAD) || (mode == RT_CAPTURE));
   assign ext_reload  = ext_ev && (mode == RT_RELOAD);
   assign ext_capture = ext_ev && (mode == RT_CAPTURE);

endmodule

// File: rtl/rt16_cnt.sv
module rt16_cnt #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_count,
   input  logic          wr_reload,
   input  logic [CW-1:0] wd,
   input  logic          inc,
   input  logic          count_up,
   input  logic          wrap_zero,
   input  logic          ext_reload,
   input  logic          ext_capture,
   output logic [CW-1:0] count,
   output logic [CW-1:0] reload,
   output logic          wrap
);

   localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

   logic [CW-1:0] nxt;

   always_comb begin
      nxt  = count;
      wrap = 1'b0;
      if (inc) begin
         if (count_up) begin
            if (count == ALL_ONES) begin
               wrap = 1'b1;
               nxt  = wrap_zero ? '0 : reload;
            end else begin
               nxt = count + 1'b1;
            end
         end else begin
            if (count == reload) begin
               wrap = 1'b1;
               nxt  = ALL_ONES;
            end else begin
               nxt = count - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          count <= '0;
      else if (wr_count)   count <= wd;
      else if (ext_reload) count <= reload;
      else                 count <= nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           reload <= '0;
      else if (wr_reload)   reload <= wd;
      else if (ext_capture) reload <= count;
   end

endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
   import rt16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_tick,
   input  logic             st_tick,
   input  logic             cnt_pin,
   input  logic             trg_pin,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [7:0]       ctrl_o,
   output logic             dcen_o,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             irq_o,
   output logic             tx_baud_o,
   output logic             rx_baud_o
);

   generate
      if (CNT_W < 8 || CNT_W > 32) begin : g_bad_width
         $error("reload_timer16: CNT_W must lie in 8..32");
      end
   endgenerate

   rt16_ctrl_t ctrl_q;
   logic       dcen_q;
   logic       tx_q, rx_q;
   logic [1:0] falls;
   rt16_mode_e mode;
   logic       baud, updown, inc, count_up, wrap_zero;
   logic       ext_reload, ext_capture, wrap;

   rt16_fall #(.N(2)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_en (mc_tick),
      .pin    ({trg_pin, cnt_pin}),
      .fall   (falls)
   );

   rt16_ctl u_ctl (
      .ctrl        (ctrl_q),
      .dcen        (dcen_q),
      .mc_tick     (mc_tick),
      .st_tick     (st_tick),
      .cnt_fall    (falls[0]),
      .trg_fall    (falls[1]),
      .trg_pin     (trg_pin),
      .mode        (mode),
      .baud        (baud),
      .updown      (updown),
      .inc         (inc),
      .count_up    (count_up),
      .wrap_zero   (wrap_zero),
      .ext_reload  (ext_reload),
      .ext_capture (ext_capture)
   );

   rt16_cnt #(.CW(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_count    (wr_en && wr_sel == SEL_COUNT),
      .wr_reload   (wr_en && wr_sel == SEL_RELOAD),
      .wd          (wr_data),
      .inc         (inc),
      .count_up    (count_up),
      .wrap_zero   (wrap_zero),
      .ext_reload  (ext_reload),
      .ext_capture (ext_capture),
      .count       (count_o),
      .reload      (reload_o),
      .wrap        (wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en && wr_sel == SEL_CTRL) begin
         ctrl_q <= rt16_ctrl_t'(wr_data[7:0]);
      end else begin
         if (wrap && !baud) ctrl_q.of_flag <= 1'b1;
         if (ext_reload || ext_capture) ctrl_q.ex_flag <= 1'b1;
         else if (wrap && updown)       ctrl_q.ex_flag <= ~ctrl_q.ex_flag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           dcen_q <= 1'b0;
      else if (wr_en && wr_sel == SEL_OPT)  dcen_q <= wr_data[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q <= 1'b0;
         rx_q <= 1'b0;
      end else begin
         tx_q <= wrap && (mode == RT_BAUD) && ctrl_q.tx_sel;
         rx_q <= wrap && (mode == RT_BAUD) && ctrl_q.rx_sel;
      end
   end

   assign ctrl_o    = ctrl_q;
   assign dcen_o    = dcen_q;
   assign irq_o     = ctrl_q.of_flag | (ctrl_q.ex_flag & ~updown);
   assign tx_baud_o = tx_q;
   assign rx_baud_o = rx_q;

endmodule

// File: rtl/rt16_chk.sv
module rt16_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    ctrl,
   input logic [CW-1:0] count,
   input logic [CW-1:0] reload,
   input logic          tx_p,
   input logic          rx_p
);

   // R2: stopped timer keeps its count unless software writes
   a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[2] && !wr_en) |=> $stable(count));

   // R10: overflow flag cannot become set while a baud select is on
   a_r10_no_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl[5] || ctrl[4]) && !ctrl[7] && !wr_en) |=> !ctrl[7]);

   // R10: a baud pulse coincides with the reloaded counter value
   a_r10_pulse_reload: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_p || rx_p) && !$past(wr_en)) |-> (count == reload));

   // R4: overflow flag rises only from an all-ones or reload-equal count
   a_r4_of_source: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl[7]) && !$past(wr_en)) |->
      ($past(count) == {CW{1'b1}} || $past(count) == $past(reload)));

   // R6: in capture mode a rising external flag means the count was copied
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl[6]) && !$past(wr_en) && $past(ctrl[0]) &&
       !$past(ctrl[5]) && !$past(ctrl[4])) |-> (reload == $past(count)));

endmodule

bind reload_timer16 rt16_chk #(.CW(CNT_W)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .ctrl   (ctrl_o),
   .count  (count_o),
   .reload (reload_o),
   .tx_p   (tx_baud_o),
   .rx_p   (rx_baud_o)
);

// File: tb/test_reload_timer16.sv
module test_reload_timer16;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   localparam logic [7:0] B_OF  = 8'h80, B_EX  = 8'h40, B_RX  = 8'h20, B_TX = 8'h10;
   localparam logic [7:0] B_EE  = 8'h08, B_RUN = 8'h04, B_CNT = 8'h02, B_CAP = 8'h01;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mc_tick = 1'b0, st_tick = 1'b0;
   logic          cnt_pin = 1'b1, trg_pin = 1'b1;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [CW-1:0] wr_data = '0;
   logic [7:0]    ctrl_o;
   logic          dcen_o, irq_o, tx_baud_o, rx_baud_o;
   logic [CW-1:0] count_o, reload_o;

   int total = 0;
   int bad = 0;

   reload_timer16 #(.CNT_W(CW)) i_reload_timer16 (
      .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .st_tick(st_tick),
      .cnt_pin(cnt_pin), .trg_pin(trg_pin), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ctrl_o(ctrl_o), .dcen_o(dcen_o), .count_o(count_o),
      .reload_o(reload_o), .irq_o(irq_o), .tx_baud_o(tx_baud_o), .rx_baud_o(rx_baud_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic mc, input logic st);
      mc_tick = mc; st_tick = st;
      @(posedge clk); #1;
      mc_tick = 1'b0; st_tick = 1'b0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wrtick(input logic [1:0] s, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d; mc_tick = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0; mc_tick = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk("R1 ctrl", ctrl_o, 0);
      chk("R1 count", count_o, 0);
      chk("R1 reload", reload_o, 0);
      chk("R1 dcen", dcen_o, 0);
      chk("R1 irq/pulses", {irq_o, tx_baud_o, rx_baud_o}, 0);

      // R2 stopped
      wr(2, 8'h05);
      for (int k = 0; k < 4; k++) step(1'b1, 1'b1);
      chk("R2 count held", count_o, 8'h05);
      chk("R2 flags", ctrl_o, 0);

      // R3 capture-mode timer sweep
      for (int s = 0; s < 256; s += 15) begin
         wr(0, B_RUN | B_CAP);
         wr(2, s[7:0]);
         step(1'b0, 1'b1);
         chk("R3 st ignored", count_o, s);
         for (int k = 0; k < 255 - s; k++) step(1'b1, 1'b0);
         chk("R3 at max", {ctrl_o[7], count_o}, {1'b0, 8'hFF});
         step(1'b1, 1'b0);
         chk("R3 wrap zero", count_o, 0);
         chk("R3 of/irq", {ctrl_o[7], irq_o}, 2'b11);
      end

      // R4 auto-reload sweep
      for (int r = 0; r < 256; r += 51) begin
         wr(0, B_RUN);
         wr(3, r[7:0]);
         wr(2, 8'hFD);
         step(1'b1, 1'b0);
         step(1'b1, 1'b0);
         chk("R4 before wrap", {ctrl_o[7], count_o}, {1'b0, 8'hFF});
         step(1'b1, 1'b0);
         chk("R4 reloaded", count_o, r);
         chk("R4 of", ctrl_o, B_RUN | B_OF);
      end
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      chk("R4 sticky", ctrl_o[7], 1);

      // R5 external reload
      wr(0, B_RUN | B_EE);
      wr(3, 8'h40);
      wr(2, 8'h10);
      trg_pin = 1'b1; step(1'b1, 1'b0);
      chk("R5 pre", count_o, 8'h11);
      trg_pin = 1'b0; step(1'b1, 1'b0);
      chk("R5 reload", count_o, 8'h40);
      chk("R5 ex/irq", {ctrl_o, irq_o}, {B_RUN | B_EE | B_EX, 1'b1});
      step(1'b1, 1'b0);
      chk("R5 no repeat", count_o, 8'h41);
      wr(0, B_RUN);
      trg_pin = 1'b1; step(1'b1, 1'b0);
      trg_pin = 1'b0; step(1'b1, 1'b0);
      chk("R5 disabled count", count_o, 8'h43);
      chk("R5 disabled flags", ctrl_o, B_RUN);

      // R6 capture
      wr(0, B_RUN | B_EE | B_CAP);
      wr(3, 8'h00);
      wr(2, 8'h30);
      trg_pin = 1'b1; step(1'b1, 1'b0);
      trg_pin = 1'b0; step(1'b1, 1'b0);
      chk("R6 captured", reload_o, 8'h31);
      chk("R6 count runs", count_o, 8'h32);
      chk("R6 ex", ctrl_o, B_RUN | B_EE | B_CAP | B_EX);

      // R7 event counter
      wr(0, B_RUN | B_CNT);
      wr(2, 8'h00);
      cnt_pin = 1'b1; step(1'b1, 1'b0);
      chk("R7 high no count", count_o, 0);
      cnt_pin = 1'b0; step(1'b1, 1'b0);
      chk("R7 one edge", count_o, 1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      chk("R7 held low", count_o, 1);
      for (int k = 0; k < 10; k++) begin
         cnt_pin = 1'b1; step(1'b1, 1'b0);
         cnt_pin = 1'b0; step(1'b1, 1'b0);
      end
      chk("R7 ten edges", count_o, 11);
      cnt_pin = 1'b1; step(1'b0, 1'b0);
      cnt_pin = 1'b0; step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      chk("R7 between ticks", count_o, 11);
      cnt_pin = 1'b1;

      // R8 down counting
      wr(1, 8'h01);
      wr(0, B_RUN);
      wr(3, 8'h20);
      wr(2, 8'h22);
      trg_pin = 1'b0;
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      chk("R8 down", count_o, 8'h20);
      step(1'b1, 1'b0);
      chk("R8 underflow", count_o, 8'hFF);
      chk("R8 flags", ctrl_o, B_RUN | B_OF | B_EX);
      step(1'b1, 1'b0);
      chk("R8 continues", count_o, 8'hFE);

      // R9 toggle and masking
      wr(0, B_RUN | B_EE | B_EX);
      chk("R9 ex masked", irq_o, 0);
      wr(2, 8'h20);
      step(1'b1, 1'b0);
      chk("R9 toggle off", ctrl_o, B_RUN | B_EE | B_OF);
      trg_pin = 1'b1;
      wr(2, 8'hFF);
      step(1'b1, 1'b0);
      chk("R8 up reload", count_o, 8'h20);
      chk("R9 toggle on", ctrl_o, B_RUN | B_EE | B_OF | B_EX);
      wr(2, 8'h50);
      step(1'b1, 1'b0);
      trg_pin = 1'b0; step(1'b1, 1'b0);
      chk("R9 edge no reload", count_o, 8'h50);
      chk("R9 reg kept", reload_o, 8'h20);
      chk("R9 flags kept", ctrl_o, B_RUN | B_EE | B_OF | B_EX);

      // R10 baud mode
      wr(1, 8'h00);
      wr(0, B_RUN | B_TX | B_CAP);
      wr(3, 8'hF0);
      wr(2, 8'hFE);
      step(1'b1, 1'b0);
      chk("R10 mc ignored", count_o, 8'hFE);
      step(1'b0, 1'b1);
      chk("R10 st advance", {tx_baud_o, count_o}, {1'b0, 8'hFF});
      step(1'b0, 1'b1);
      chk("R10 reload", count_o, 8'hF0);
      chk("R10 tx pulse", {tx_baud_o, rx_baud_o}, 2'b10);
      chk("R10 no of", ctrl_o, B_RUN | B_TX | B_CAP);
      step(1'b0, 1'b0);
      chk("R10 pulse ends", tx_baud_o, 0);
      wr(0, B_RUN | B_RX);
      wr(2, 8'hFF);
      step(1'b0, 1'b1);
      chk("R10 rx pulse", {tx_baud_o, rx_baud_o, count_o}, {2'b01, 8'hF0});

      // R11 baud ignores trigger
      wr(0, B_RUN | B_TX | B_EE);
      wr(2, 8'h80);
      trg_pin = 1'b1; step(1'b1, 1'b0);
      trg_pin = 1'b0; step(1'b1, 1'b0);
      chk("R11 count", count_o, 8'h80);
      chk("R11 flags", ctrl_o, B_RUN | B_TX | B_EE);
      chk("R11 reload", reload_o, 8'hF0);

      // R12 write priority
      wr(0, B_RUN);
      wr(2, 8'h10);
      wrtick(2, 8'h77);
      chk("R12 count write wins", count_o, 8'h77);
      wr(2, 8'hFF);
      wr(3, 8'h33);
      wrtick(0, B_RUN);
      chk("R12 reload on wrap", count_o, 8'h33);
      chk("R12 ctrl write wins", ctrl_o, B_RUN);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule